// File: doc/BRIEF.md
# Serial Result Shifter with Selectable Data Clock

This block sends the most recent 12-bit conversion result out on a single serial line. It holds the last latched result and, once triggered, sends a framed word. The frame is one sync slot, then the result bits with the most significant bit first, then a run of tag slots. The tag slots copy a tag input onto the serial line, so several converters can be chained into one serial stream.

The data clock comes from one of two sources, chosen by a select input. With the select low, the block divides its system clock down to make the data clock and drives it onto the clock pin. That clock toggles only while a frame is in flight, and each transfer starts on its own when a new result is latched. With the select high, the clock pin becomes an input. Each falling edge of the external clock, sampled through a synchronizer, moves the frame on by one slot. Transfers then start on the read edge of the control lines: read/convert rising while chip select is low, or chip select falling while read/convert is high.

Top module: `serial_result_shifter`

## Requirements
- R1: After a synchronous reset, `sdata_o`, `sync_o` and `dclk_o` are 0 and no transfer is running.
- R2: `dclk_oe_o` is 1 when `ext_clk_sel_i` is 0 (the block drives the clock pin) and 0 when it is 1.
- R3: With `ext_clk_sel_i` low, a cycle with `result_valid_i` high starts a transfer of `result_i`. Each slot then lasts 2*HALF_DIV system cycles, and `dclk_o` is 0 in the first HALF_DIV cycles and 1 in the last HALF_DIV cycles.
- R4: Slot 0 of a frame is the sync slot: `sync_o` is 1 and `sdata_o` is 0 in that slot only.
- R5: Slots 1 to 12 carry the result, MSB first: slot k shows bit 12-k.
- R6: Slots 13 to 12+TAG_LEN each show the value `tag_i` had at the clock step that entered that slot. The frame then ends and `sdata_o` returns to 0.
- R7: While no transfer is running, `dclk_o` stays 0.
- R8: With `ext_clk_sel_i` high, a transfer starts when (`cs_n_i` low AND `rc_i` high) becomes true, in either order of the two edges. Each falling edge of `dclk_ext_i` advances one slot, and `dclk_o` stays 0.
- R9: An external-clock read sends the result latched by the most recent `result_valid_i` pulse.
- R10: Start conditions that arrive during a transfer are ignored, and the word in flight is not changed by them. A result latched during a transfer is kept for the next read.
- R11: With the external clock selected, `result_valid_i` latches the result but starts no transfer. With the internal clock selected, a read edge starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| result_i | input | 12 | Conversion result to latch |
| result_valid_i | input | 1 | One-cycle pulse: result latched at end of conversion |
| ext_clk_sel_i | input | 1 | 0 = internal data clock, 1 = external data clock |
| dclk_ext_i | input | 1 | External data clock (pin in input role) |
| cs_n_i | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read/convert control |
| tag_i | input | 1 | Chain input passed through after the result |
| sdata_o | output | 1 | Serial data |
| sync_o | output | 1 | Frame sync, high during the first slot |
| dclk_o | output | 1 | Internal data clock (pin in output role) |
| dclk_oe_o | output | 1 | Drive enable of the clock pin |

## Verification
Internal-clock frames are run for all-zeros, all-ones, both sign-boundary codes, two alternating patterns and every walking-one code. This shows whether bit order, bit position and sync placement are right. Each frame also carries a tag pattern derived from the word, which separates tag passthrough from stale result bits. External-clock reads use both orderings of the read edge, repeated triggers in mid-frame, and results latched during a transfer or in external mode. These show whether the block picks the right word and ignores starts it should not act on.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        SK_IDLE,
        SK_SYNC,
        SK_DATA,
        SK_TAG
    } slot_kind_e;

    typedef enum logic {
        CK_INT = 1'b0,
        CK_EXT = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic sdata;
        logic sync;
    } ser_pins_t;

    // Classify a slot index inside a frame of w result bits.
    function automatic slot_kind_e kind_of(input logic busy,
                                           input int unsigned slot,
                                           input int unsigned w);
        if (!busy)        return SK_IDLE;
        if (slot == 0)    return SK_SYNC;
        if (slot <= w)    return SK_DATA;
        return SK_TAG;
    endfunction

endpackage

// File: rtl/rs_clkdiv.sv
module rs_clkdiv #(
    parameter int HALF_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o,
    output logic level_o
);
    localparam int PERIOD = 2 * HALF_DIV;
    localparam int CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(PERIOD - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o  = run_i && (cnt_q == CNT_W'(PERIOD - 1));
    assign level_o = run_i && (cnt_q >= CNT_W'(HALF_DIV));

    // R3: counter advances by one per cycle inside a slot
    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        (run_i && cnt_q != CNT_W'(PERIOD - 1)) |=> (!run_i || cnt_q == $past(cnt_q) + 1'b1));

    // R7: clock level falls back to low once the divider stops
    a_r7_stop_low: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (!run_i -> !level_o));

endmodule

// File: rtl/rs_input_cond.sv
module rs_input_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dclk_ext_i,
    input  logic cs_n_i,
    input  logic rc_i,
    output logic ext_fall_o,
    output logic rd_rise_o
);
    logic [SYNC_STAGES:0] pipe_q;
    logic                 rd_q;
    logic                 rd_now;

    assign rd_now = !cs_n_i && rc_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
            rd_q   <= 1'b0;
        end else begin
            pipe_q <= {pipe_q[SYNC_STAGES-1:0], dclk_ext_i};
            rd_q   <= rd_now;
        end
    end

    assign ext_fall_o = pipe_q[SYNC_STAGES] && !pipe_q[SYNC_STAGES-1];
    assign rd_rise_o  = rd_now && !rd_q;

    // R8: one slot step per external falling edge
    a_r8_single_fall: assert property (@(posedge clk) disable iff (rst)
        ext_fall_o |=> !ext_fall_o);

endmodule

// File: rtl/rs_shift_seq.sv
module rs_shift_seq
    import rs_pkg::*;
#(
    parameter int WIDTH   = 12,
    parameter int TAG_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] load_i,
    input  logic             tick_i,
    input  logic             tag_i,
    output logic             busy_o,
    output ser_pins_t        pins_o
);
    localparam int LAST   = WIDTH + TAG_LEN;
    localparam int SLOT_W = $clog2(LAST + 1);

    logic              busy_q;
    logic [SLOT_W-1:0] slot_q;
    logic [WIDTH-1:0]  sh_q;
    logic              tag_q;
    slot_kind_e        kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            slot_q <= '0;
            sh_q   <= '0;
            tag_q  <= 1'b0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                slot_q <= '0;
                sh_q   <= load_i;
            end
        end else if (tick_i) begin
            if (slot_q == SLOT_W'(LAST)) begin
                busy_q <= 1'b0;
                slot_q <= '0;
            end else begin
                slot_q <= slot_q + 1'b1;
                if (slot_q >= SLOT_W'(1) && slot_q < SLOT_W'(WIDTH)) begin
                    sh_q <= {sh_q[WIDTH-2:0], 1'b0};
                end
                if (slot_q >= SLOT_W'(WIDTH)) begin
                    tag_q <= tag_i;
                end
            end
        end
    end

    assign kind   = kind_of(busy_q, 32'(slot_q), WIDTH);
    assign busy_o = busy_q;

    always_comb begin
        pins_o = '0;
        unique case (kind)
            SK_SYNC: pins_o.sync  = 1'b1;
            SK_DATA: pins_o.sdata = sh_q[WIDTH-1];
            SK_TAG:  pins_o.sdata = tag_q;
            default: pins_o       = '0;
        endcase
    end

    // R10: word in flight moves only on a clock step
    a_r10_word_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tick_i) |=> $stable(sh_q));

    // R10: a start request during a transfer does not rewind the slot
    a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start_i && !tick_i) |=> (busy_q && $stable(slot_q)));

    // R6: slot index never passes the end of the frame
    a_r6_slot_bound: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (slot_q <= SLOT_W'(LAST)));

    // R4: sync appears only right after a start or never again in a frame
    a_r4_sync_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_o.sync) |-> $rose(busy_q));

endmodule

// File: rtl/serial_result_shifter.sv
module serial_result_shifter
    import rs_pkg::*;
#(
    parameter int WIDTH       = 12,
    parameter int TAG_LEN     = 4,
    parameter int HALF_DIV    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] result_i,
    input  logic             result_valid_i,
    input  logic             ext_clk_sel_i,
    input  logic             dclk_ext_i,
    input  logic             cs_n_i,
    input  logic             rc_i,
    input  logic             tag_i,
    output logic             sdata_o,
    output logic             sync_o,
    output logic             dclk_o,
    output logic             dclk_oe_o
);
    clk_src_e         src_now;
    clk_src_e         src_q;
    logic [WIDTH-1:0] word_q;
    logic             busy;
    logic             start;
    logic [WIDTH-1:0] load;
    logic             div_tick;
    logic             div_level;
    logic             ext_fall;
    logic             rd_rise;
    logic             tick;
    ser_pins_t        pins;

    assign src_now = clk_src_e'(ext_clk_sel_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            src_q  <= CK_INT;
        end else begin
            if (result_valid_i) word_q <= result_i;
            if (!busy && start) src_q <= src_now;
        end
    end

    assign start = (src_now == CK_EXT) ? rd_rise : result_valid_i;
    assign load  = (src_now == CK_EXT) ? word_q  : result_i;
    assign tick  = (src_q == CK_EXT) ? ext_fall : div_tick;

    rs_input_cond #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_cond (
        .clk        (clk),
        .rst        (rst),
        .dclk_ext_i (dclk_ext_i),
        .cs_n_i     (cs_n_i),
        .rc_i       (rc_i),
        .ext_fall_o (ext_fall),
        .rd_rise_o  (rd_rise)
    );

    rs_clkdiv #(
        .HALF_DIV(HALF_DIV)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .run_i   (busy && src_q == CK_INT),
        .tick_o  (div_tick),
        .level_o (div_level)
    );

    rs_shift_seq #(
        .WIDTH  (WIDTH),
        .TAG_LEN(TAG_LEN)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .load_i  (load),
        .tick_i  (tick),
        .tag_i   (tag_i),
        .busy_o  (busy),
        .pins_o  (pins)
    );

    assign sdata_o   = pins.sdata;
    assign sync_o    = pins.sync;
    assign dclk_o    = div_level;
    assign dclk_oe_o = (src_now == CK_INT);

    // R7: no internal clock activity between frames
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !dclk_o);

    // R8: an external-clock frame never drives the internal clock
    a_r8_ext_silent: assert property (@(posedge clk) disable iff (rst)
        (busy && src_q == CK_EXT) |-> !dclk_o);

    // R9: the held word follows each latched result
    a_r9_word_latch: assert property (@(posedge clk) disable iff (rst)
        result_valid_i |=> (word_q == $past(result_i)));

endmodule

// File: tb/serial_result_shifter_bench.sv
module serial_result_shifter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 12;
    localparam int TL   = 4;
    localparam int HALF = 2;
    localparam int LAST = W + TL;
    localparam int EXT_HALF = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] result_i = '0;
    logic         result_valid_i = 1'b0;
    logic         ext_clk_sel_i = 1'b0;
    logic         dclk_ext_i = 1'b1;
    logic         cs_n_i = 1'b1;
    logic         rc_i = 1'b0;
    logic         tag_i = 1'b0;
    logic         sdata_o, sync_o, dclk_o, dclk_oe_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_result_shifter #(
        .WIDTH(W), .TAG_LEN(TL), .HALF_DIV(HALF), .SYNC_STAGES(2)
    ) u_serial_result_shifter (
        .clk(clk), .rst(rst), .result_i(result_i), .result_valid_i(result_valid_i),
        .ext_clk_sel_i(ext_clk_sel_i), .dclk_ext_i(dclk_ext_i), .cs_n_i(cs_n_i),
        .rc_i(rc_i), .tag_i(tag_i), .sdata_o(sdata_o), .sync_o(sync_o),
        .dclk_o(dclk_o), .dclk_oe_o(dclk_oe_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [LAST:0] tag_pat(input logic [W-1:0] w);
        logic [LAST:0] p;
        for (int k = 0; k <= LAST; k++) p[k] = w[k % W] ^ k[0];
        return p;
    endfunction

    function automatic logic exp_sd(input int k, input logic [W-1:0] w, input logic [LAST:0] tp);
        if (k == 0) return 1'b0;
        if (k <= W) return w[W-k];
        return tp[k];
    endfunction

    task automatic check_slot(input string req, input int k, input logic [W-1:0] w,
                              input logic [LAST:0] tp);
        chk(k == 0 ? "R4 sync slot" : (k <= W ? req : "R6 tag slot"),
            {14'd0, sync_o, sdata_o}, {14'd0, (k == 0), exp_sd(k, w, tp)});
    endtask

    // Internal-clock frame; optionally latch alt mid-frame (R10)
    task automatic xfer_int(input logic [W-1:0] w, input bit disturb, input logic [W-1:0] alt);
        logic [LAST:0] tp = tag_pat(w);
        result_i = w; result_valid_i = 1'b1;
        @(posedge clk); @(negedge clk);
        result_valid_i = 1'b0;
        for (int k = 0; k <= LAST; k++) begin
            check_slot("R5 data bit int", k, w, tp);
            chk("R3 dclk low half", {15'd0, dclk_o}, 16'd0);
            if (disturb && k == 5) begin
                result_i = alt; result_valid_i = 1'b1;
                @(posedge clk); @(negedge clk);
                result_valid_i = 1'b0;
                repeat (HALF - 1) @(posedge clk);
            end else begin
                repeat (HALF) @(posedge clk);
            end
            @(negedge clk);
            chk("R3 dclk high half", {15'd0, dclk_o}, 16'd1);
            check_slot("R10 data held int", k, w, tp);
            if (k < LAST) tag_i = tp[k+1];
            repeat (HALF) @(posedge clk);
            @(negedge clk);
        end
        chk("R6 frame end", {14'd0, sync_o, sdata_o}, 16'd0);
        repeat (6) @(negedge clk);
        chk("R7 idle clock low", {15'd0, dclk_o}, 16'd0);
    endtask

    // External-clock read; order 0: rc rises with cs low, 1: cs falls with rc high
    task automatic xfer_ext(input logic [W-1:0] w, input bit order, input bit retrig);
        logic [LAST:0] tp = tag_pat(w);
        if (!order) begin
            cs_n_i = 1'b0; @(negedge clk); rc_i = 1'b1;
        end else begin
            rc_i = 1'b1; @(negedge clk); cs_n_i = 1'b0;
        end
        @(negedge clk);
        for (int k = 0; k <= LAST; k++) begin
            check_slot(order ? "R8 data bit cs edge" : "R8 data bit rc edge", k, w, tp);
            chk("R8 no internal clock", {14'd0, dclk_o, dclk_oe_o}, 16'd0);
            if (retrig && k == 3) begin
                cs_n_i = 1'b1; @(negedge clk); cs_n_i = 1'b0; @(negedge clk);
                check_slot("R10 retrigger ignored", k, w, tp);
            end
            if (k < LAST) tag_i = tp[k+1];
            dclk_ext_i = 1'b0;
            repeat (EXT_HALF) @(negedge clk);
            dclk_ext_i = 1'b1;
            repeat (EXT_HALF) @(negedge clk);
        end
        chk("R8 frame end", {14'd0, sync_o, sdata_o}, 16'd0);
        cs_n_i = 1'b1; rc_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic watch_no_start(input string req, input int cycles);
        logic seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            seen = seen | sync_o | dclk_o;
        end
        chk(req, {15'd0, seen}, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {13'd0, sdata_o, sync_o, dclk_o}, 16'd0);
        chk("R2 pin driven in internal mode", {15'd0, dclk_oe_o}, 16'd1);
        repeat (4) @(negedge clk);
        chk("R7 no clock after reset", {15'd0, dclk_o}, 16'd0);

        // R3 R5 R6: internal sweep
        xfer_int(12'h000, 0, '0);
        xfer_int(12'hFFF, 0, '0);
        xfer_int(12'h800, 0, '0);
        xfer_int(12'h7FF, 0, '0);
        xfer_int(12'hA5A, 0, '0);
        xfer_int(12'h5A5, 0, '0);
        for (int i = 0; i < W; i++) xfer_int(W'(1) << i, 0, '0);
        // R10: result latched mid-frame does not disturb the frame
        xfer_int(12'h3C3, 1, 12'hC3C);

        // R2 select external
        ext_clk_sel_i = 1'b1;
        @(negedge clk);
        chk("R2 pin released in external mode", {15'd0, dclk_oe_o}, 16'd0);
        // R9 R10: read returns the word latched during the last frame
        xfer_ext(12'hC3C, 0, 0);
        // R11: latch in external mode starts nothing
        result_i = 12'h123; result_valid_i = 1'b1;
        @(negedge clk);
        result_valid_i = 1'b0;
        watch_no_start("R11 no start on result in ext mode", 12);
        xfer_ext(12'h123, 1, 1);
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] w = W'((i * 12'h2B7) ^ 12'h9E1);
            result_i = w; result_valid_i = 1'b1;
            @(negedge clk);
            result_valid_i = 1'b0;
            @(negedge clk);
            xfer_ext(w, i[0], i == 2);
        end

        // R11: read edge in internal mode starts nothing
        ext_clk_sel_i = 1'b0;
        @(negedge clk);
        chk("R2 pin driven again", {15'd0, dclk_oe_o}, 16'd1);
        cs_n_i = 1'b0; @(negedge clk); rc_i = 1'b1;
        watch_no_start("R11 no start on read in int mode", 12);
        cs_n_i = 1'b1; rc_i = 1'b0;
        @(negedge clk);
        xfer_int(12'h6D2, 0, '0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule